// File: doc/BRIEF.md
# Branch Squash and Redirect Controller

This block resolves control hazards for a six-stage in-order pipeline (fetch, decode, register read, execute, memory, writeback). Branch conditions and targets are worked out in the execute stage, but the fetch address is only replaced once the branch sits in the memory stage. While that branch travels down, fetch keeps running down the fall-through path. When a taken branch arrives in the memory stage, that path turns out to be wrong. The block then steers the fetch address to the target. In the same cycle it kills the four younger instructions that sit in fetch, decode, register read and execute, so each of them becomes a nop.

The block owns the fetch program counter. The counter steps by a fixed increment every cycle, holds while an upstream data-hazard stall is raised, and loads the branch target on a redirect. For each young stage it returns the valid bit that the pipeline register should keep, along with a register write-enable and a memory write-enable. Squashed instructions therefore cannot change architectural state in any later stage. The memory and writeback stages are never killed, so instructions older than the branch complete normally. There is no prediction and no delay slot: every taken branch costs four cycles.

Top module: `brsq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetchPc` equals `RESET_PC` (default 0x0000_1000). `pcSel`, `fetchHold` and all `stgKill` bits are 0.
- R2: With no redirect and no stall, `fetchPc` advances by `PC_STEP` (default 4) at every clock edge.
- R3: A taken branch is one where `memValid`=1 and `memBrTaken`=1. In the cycle a taken branch is present, `pcSel` is 1 and all four `stgKill` bits are 1. Bit 0 is fetch, bit 1 decode, bit 2 register read, bit 3 execute.
- R4: After a taken branch, `fetchPc` equals `memTarget` in the next cycle. It then resumes stepping by `PC_STEP` from there (target+4, target+8).
- R5: A branch with `memValid`=1 and `memBrTaken`=0 gives `pcSel`=0 and `stgKill`=0. `fetchPc` keeps stepping.
- R6: With `memValid`=0, a raised `memBrTaken` has no effect. `pcSel` is 0, `stgKill` is 0 and `fetchPc` keeps stepping.
- R7: With `hazardStall`=1 and no taken branch, `fetchHold` is 1 and `fetchPc` keeps its value across the edge.
- R8: A taken branch takes priority over `hazardStall` in the same cycle. `fetchHold` is 0, every kill bit is 1, and `fetchPc` loads the target.
- R9: For each young stage i, `stgValidOut[i]` = `stgValid[i]` and not killed. `stgRegWeOut[i]` and `stgMemWeOut[i]` are the incoming enables ANDed with `stgValidOut[i]`. A squashed or invalid stage therefore drives both enables to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stgValid | input | 4 | Valid bits of the young stages (bit0 fetch .. bit3 execute) |
| stgRegWe | input | 4 | Register write-enables carried by the young stages |
| stgMemWe | input | 4 | Memory write-enables carried by the young stages |
| hazardStall | input | 1 | Data-hazard stall request from the interlock |
| memValid | input | 1 | Memory-stage instruction is valid |
| memBrTaken | input | 1 | Memory-stage branch was resolved taken |
| memTarget | input | ADDR_W | Branch target from the memory stage |
| fetchPc | output | ADDR_W | Current fetch address |
| pcSel | output | 1 | 1 selects the branch target as the next fetch address |
| fetchHold | output | 1 | Fetch address is being held by a stall |
| stgKill | output | 4 | Per-stage squash strobes |
| stgValidOut | output | 4 | Valid bits after the squash |
| stgRegWeOut | output | 4 | Gated register write-enables |
| stgMemWeOut | output | 4 | Gated memory write-enables |

## Verification
The bench targets a taken flag that arrives with an invalid memory-stage slot. A design that ignored the valid bit would redirect on a bubble and kill good instructions. It also raises a stall in the same cycle as a taken branch. If the stall won, the fetch address would freeze, the target would be lost, and the wrong path would keep running. Further checks follow the fetch address for two cycles after the redirect, which exposes an off-by-one step or a target that is late by one cycle. The bench also applies write-enables to killed stages, which exposes any stage that still commits a store or a register write after being squashed.

// File: rtl/brsq_pkg.sv
package brsq_pkg;
  localparam int NUM_YOUNG = 4;

  typedef enum logic [1:0] {
    STG_FETCH  = 2'd0,
    STG_DECODE = 2'd1,
    STG_READ   = 2'd2,
    STG_EXEC   = 2'd3
  } youngStage_e;

  typedef struct packed {
    logic redirect;
    logic hold;
  } pcStrobe_t;
endpackage

// File: rtl/brsq_pc_path.sv
module brsq_pc_path
  import brsq_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    if (strobe.redirect)  pcNext = target;
    else if (strobe.hold) pcNext = pc;
    else                  pcNext = pc + STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= RESET_PC;
    else       pc <= pcNext;
  end

  // R4: the cycle after a redirect the target is fetched
  a_r4_target_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.redirect |=> pc == $past(target));
  // R7: a stall without a redirect freezes the fetch address
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hold && !strobe.redirect) |=> $stable(pc));
  // R2: sequential step
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.hold && !strobe.redirect) |=> pc == $past(pc) + STEP);
endmodule

// File: rtl/brsq_ctl.sv
module brsq_ctl
  import brsq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_YOUNG-1:0] stgValid,
  input  logic [NUM_YOUNG-1:0] stgRegWe,
  input  logic [NUM_YOUNG-1:0] stgMemWe,
  input  logic                 hazardStall,
  input  logic                 memValid,
  input  logic                 memBrTaken,
  output pcStrobe_t            strobe,
  output logic [NUM_YOUNG-1:0] stgKill,
  output logic [NUM_YOUNG-1:0] stgValidOut,
  output logic [NUM_YOUNG-1:0] stgRegWeOut,
  output logic [NUM_YOUNG-1:0] stgMemWeOut
);
  logic takenBr;

  // Only a real instruction in the memory stage may redirect fetch.
  assign takenBr = memValid & memBrTaken;

  // A redirect overrides any stall raised in the same cycle.
  always_comb begin
    strobe.redirect = takenBr;
    strobe.hold     = hazardStall & ~takenBr;
  end

  for (genvar s = 0; s < NUM_YOUNG; s++) begin : g_stage
    logic keep;
    assign stgKill[s]     = takenBr;
    assign keep           = stgValid[s] & ~stgKill[s];
    assign stgValidOut[s] = keep;
    assign stgRegWeOut[s] = stgRegWe[s] & keep;
    assign stgMemWeOut[s] = stgMemWe[s] & keep;

    // R9: a killed stage never commits a write
    a_r9_no_write_when_killed: assert property (@(posedge clk) disable iff (!rstN)
      stgKill[s] |-> !stgRegWeOut[s] && !stgMemWeOut[s] && !stgValidOut[s]);
  end

  // R3: a taken branch kills every young stage
  a_r3_kill_all: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memBrTaken) |-> (&stgKill) && strobe.redirect);
  // R6: a bubble in the memory stage never squashes
  a_r6_bubble_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> stgKill == '0 && !strobe.redirect);
  // R8: redirect and hold are never both active
  a_r8_priority: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.redirect && strobe.hold));
endmodule

// File: rtl/brsq_top.sv
module brsq_top
  import brsq_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        stgValid,
  input  logic [3:0]        stgRegWe,
  input  logic [3:0]        stgMemWe,
  input  logic              hazardStall,
  input  logic              memValid,
  input  logic              memBrTaken,
  input  logic [ADDR_W-1:0] memTarget,
  output logic [ADDR_W-1:0] fetchPc,
  output logic              pcSel,
  output logic              fetchHold,
  output logic [3:0]        stgKill,
  output logic [3:0]        stgValidOut,
  output logic [3:0]        stgRegWeOut,
  output logic [3:0]        stgMemWeOut
);
  pcStrobe_t strobe;

  brsq_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .stgValid    (stgValid),
    .stgRegWe    (stgRegWe),
    .stgMemWe    (stgMemWe),
    .hazardStall (hazardStall),
    .memValid    (memValid),
    .memBrTaken  (memBrTaken),
    .strobe      (strobe),
    .stgKill     (stgKill),
    .stgValidOut (stgValidOut),
    .stgRegWeOut (stgRegWeOut),
    .stgMemWeOut (stgMemWeOut)
  );

  brsq_pc_path #(
    .ADDR_W   (ADDR_W),
    .PC_STEP  (PC_STEP),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .target (memTarget),
    .pc     (fetchPc)
  );

  assign pcSel     = strobe.redirect;
  assign fetchHold = strobe.hold;
endmodule

// File: tb/brsq_top_tb.sv
module brsq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 0;
  logic        rstN;
  logic [3:0]  stgValid, stgRegWe, stgMemWe;
  logic        hazardStall, memValid, memBrTaken;
  logic [31:0] memTarget;
  logic [31:0] fetchPc;
  logic        pcSel, fetchHold;
  logic [3:0]  stgKill, stgValidOut, stgRegWeOut, stgMemWeOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  brsq_top u_dut (
    .clk(clk), .rstN(rstN), .stgValid(stgValid), .stgRegWe(stgRegWe),
    .stgMemWe(stgMemWe), .hazardStall(hazardStall), .memValid(memValid),
    .memBrTaken(memBrTaken), .memTarget(memTarget), .fetchPc(fetchPc),
    .pcSel(pcSel), .fetchHold(fetchHold), .stgKill(stgKill),
    .stgValidOut(stgValidOut), .stgRegWeOut(stgRegWeOut), .stgMemWeOut(stgMemWeOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    stgValid = 4'hF; stgRegWe = 4'h0; stgMemWe = 4'h0;
    hazardStall = 0; memValid = 0; memBrTaken = 0; memTarget = '0;
  endtask

  // Inputs are set just after a falling edge. Outputs that depend on them
  // are checked 1 ns later. The next falling edge follows a rising edge.
  task automatic advance();
    @(negedge clk);
  endtask

  task automatic testReset();
    idleInputs();
    rstN = 0;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", fetchPc, RST_PC);
    rstN = 1;
    #1;
    chk("R1 pcSel", {31'd0, pcSel}, 32'd0);
    chk("R1 hold", {31'd0, fetchHold}, 32'd0);
    chk("R1 kill", {28'd0, stgKill}, 32'd0);
    chk("R1 pc after reset", fetchPc, RST_PC);
    expPc = RST_PC;
  endtask

  task automatic testSequential();
    idleInputs();
    for (int i = 0; i < 3; i++) begin
      advance();
      expPc = expPc + 32'd4;
      chk("R2 sequential step", fetchPc, expPc);
    end
  endtask

  task automatic testTaken();
    idleInputs();
    memValid = 1; memBrTaken = 1; memTarget = 32'h0000_4000;
    #1;
    chk("R3 pcSel taken", {31'd0, pcSel}, 32'd1);
    chk("R3 kill all", {28'd0, stgKill}, 32'hF);
    advance();
    idleInputs();
    chk("R4 target fetched", fetchPc, 32'h0000_4000);
    advance();
    chk("R4 target+4", fetchPc, 32'h0000_4004);
    advance();
    chk("R4 target+8", fetchPc, 32'h0000_4008);
    expPc = 32'h0000_4008;
  endtask

  task automatic testNotTaken();
    idleInputs();
    memValid = 1; memBrTaken = 0; memTarget = 32'h0000_8000;
    #1;
    chk("R5 pcSel", {31'd0, pcSel}, 32'd0);
    chk("R5 kill", {28'd0, stgKill}, 32'd0);
    advance();
    expPc = expPc + 32'd4;
    chk("R5 pc steps", fetchPc, expPc);
  endtask

  task automatic testBubble();
    idleInputs();
    memValid = 0; memBrTaken = 1; memTarget = 32'h0000_9000;
    #1;
    chk("R6 pcSel", {31'd0, pcSel}, 32'd0);
    chk("R6 kill", {28'd0, stgKill}, 32'd0);
    advance();
    expPc = expPc + 32'd4;
    chk("R6 pc steps", fetchPc, expPc);
  endtask

  task automatic testStall();
    idleInputs();
    hazardStall = 1;
    #1;
    chk("R7 hold", {31'd0, fetchHold}, 32'd1);
    advance();
    chk("R7 pc held", fetchPc, expPc);
    advance();
    chk("R7 pc held 2", fetchPc, expPc);
    idleInputs();
    advance();
    expPc = expPc + 32'd4;
    chk("R7 release", fetchPc, expPc);
  endtask

  task automatic testStallVsBranch();
    idleInputs();
    hazardStall = 1; memValid = 1; memBrTaken = 1; memTarget = 32'h0000_A000;
    #1;
    chk("R8 hold dropped", {31'd0, fetchHold}, 32'd0);
    chk("R8 kill", {28'd0, stgKill}, 32'hF);
    advance();
    idleInputs();
    chk("R8 target wins", fetchPc, 32'h0000_A000);
    expPc = 32'h0000_A000;
  endtask

  task automatic testGating();
    idleInputs();
    stgValid = 4'b1011; stgRegWe = 4'b1111; stgMemWe = 4'b0110;
    #1;
    chk("R9 valid pass", {28'd0, stgValidOut}, 32'hB);
    chk("R9 regwe gated by valid", {28'd0, stgRegWeOut}, 32'hB);
    chk("R9 memwe gated by valid", {28'd0, stgMemWeOut}, 32'h2);
    memValid = 1; memBrTaken = 1; memTarget = 32'h0000_B000;
    #1;
    chk("R9 valid killed", {28'd0, stgValidOut}, 32'h0);
    chk("R9 regwe killed", {28'd0, stgRegWeOut}, 32'h0);
    chk("R9 memwe killed", {28'd0, stgMemWeOut}, 32'h0);
    advance();
    idleInputs();
    expPc = 32'h0000_B000;
    chk("R4 gating redirect", fetchPc, expPc);
  endtask

  initial begin
    fork
      begin
        testReset();
        testSequential();
        testTaken();
        testNotTaken();
        testBubble();
        testStall();
        testStallVsBranch();
        testGating();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule